// File: doc/BRIEF.md
# Power Domain Clock-Gating Controller

This block decides, cycle by cycle, which clocks of a single power domain may run. It drives one registered gate-enable per clock, each meant to feed a glitch-free clock-gate cell. Four clocks are covered. The first is a shared interface clock that serves several modules. The second is a slow functional clock shared by several users. The third is a save-restore clock whose life follows the domain's context save and restore sequence. The fourth is a functional clock derived from a PLL.

The interface clock combines software control with hardware handshaking. Each served module has an enable bit, an automatic-idle bit and a clock-request line. A module that is enabled with automatic idle cleared keeps the clock running. A module that has automatic idle set may let the clock stop once it drops its request. It reports that it has done so through a per-module idle-acknowledge output. The clock stops only after every enabled module has acknowledged idle. The clock returns at the next edge when an enabled module raises its request.

Top module: `pdcg_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, `ick_gate_en` becomes 1, and `slow_gate_en`, `sr_gate_en`, `pll_gate_en` and every `idle_ack` bit become 0.
- R2: When every bit of `mod_en` is 0 at a rising edge, `ick_gate_en` is 0 after that edge.
- R3: When any module has `mod_en`=1 and `mod_autoidle`=0 at a rising edge, `ick_gate_en` is 1 after that edge, whatever `mod_req` shows.
- R4: After each rising edge, `idle_ack[i]` equals `mod_autoidle[i]` AND NOT `mod_req[i]`, as sampled at that edge. It is therefore asserted one cycle after the request drops with automatic idle set.
- R5: `ick_gate_en` becomes 0 only at an edge where every module has either `mod_en`=0, or `mod_autoidle`=1, `idle_ack`=1 and `mod_req`=0. This includes the case where every module is enabled with automatic idle, and the mixed case where one such module is enabled and the rest are disabled. Otherwise it becomes 1.
- R6: When an enabled module has `mod_req`=1 at a rising edge, `ick_gate_en` is 1 after that edge.
- R7: After each edge, `slow_gate_en` is 1 exactly when at least one `slow_en` bit was 1.
- R8: After each edge, `sr_gate_en` is 0 if `sr_enable` was 0. It is also 0 if `dom_on` was 0 and `save_done` was 1, or if `dom_on` was 1 and `restore_done` was 1. Otherwise it is 1.
- R9: After each edge, `pll_gate_en` is 1 only when `pll_en` was 1 and `pll_mode` was 2'b10 (locked). The codes 2'b00 (stop), 2'b01 (bypass) and 2'b11 (reserved) give 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mod_en | input | N_MOD | Per-module interface clock enable |
| mod_autoidle | input | N_MOD | Per-module automatic-idle permission |
| mod_req | input | N_MOD | Per-module hardware clock request |
| idle_ack | output | N_MOD | Per-module idle acknowledge |
| slow_en | input | N_SLOW | Enables of the slow functional clock users |
| sr_enable | input | 1 | Save-restore clock control bit |
| save_done | input | 1 | Context save has completed |
| restore_done | input | 1 | Context restore has completed |
| dom_on | input | 1 | Domain power state, 1 = on, 0 = off |
| pll_en | input | 1 | Enable of the PLL-derived clock |
| pll_mode | input | 2 | PLL mode: 00 stop, 01 bypass, 10 locked, 11 reserved |
| ick_gate_en | output | 1 | Gate enable, shared interface clock |
| slow_gate_en | output | 1 | Gate enable, slow functional clock |
| sr_gate_en | output | 1 | Gate enable, save-restore clock |
| pll_gate_en | output | 1 | Gate enable, PLL-derived clock |

## Verification
The case that is hardest to reach is the interface clock actually stopping while some modules are still enabled. This needs every enabled module to have automatic idle set, its request low, and its acknowledge already registered, all held for two consecutive cycles. Uniform random bits almost never line up this way. The stimulus therefore alternates between free random vectors and quiet stretches, in which automatic idle is forced on, requests are cleared and enables are randomized. Directed sequences cover the mixed single-module case, the acknowledge latency and the wake-up on a new request.

// File: rtl/pdcg_pkg.sv
package pdcg_pkg;
   typedef enum logic [1:0] {
      PLL_STOP   = 2'b00,
      PLL_BYPASS = 2'b01,
      PLL_LOCKED = 2'b10,
      PLL_RSVD   = 2'b11
   } pll_mode_e;
endpackage

// File: rtl/pdcg_gate_flop.sv
module pdcg_gate_flop #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= d;
   end
endmodule

// File: rtl/pdcg_mod_idle.sv
module pdcg_mod_idle (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic autoidle,
   input  logic req,
   output logic ack,
   output logic idle_ok
);
   logic ack_q;

   always_ff @(posedge clk) begin
      if (!rst_n) ack_q <= 1'b0;
      else        ack_q <= autoidle & ~req;
   end

   assign ack     = ack_q;
   // a live request wakes the clock at once, not one cycle later
   assign idle_ok = ~en | (autoidle & ack_q & ~req);
endmodule

// File: rtl/pdcg_ctrl.sv
module pdcg_ctrl
   import pdcg_pkg::*;
#(
   parameter int N_MOD  = 4,
   parameter int N_SLOW = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_MOD-1:0]  mod_en,
   input  logic [N_MOD-1:0]  mod_autoidle,
   input  logic [N_MOD-1:0]  mod_req,
   output logic [N_MOD-1:0]  idle_ack,
   input  logic [N_SLOW-1:0] slow_en,
   input  logic              sr_enable,
   input  logic              save_done,
   input  logic              restore_done,
   input  logic              dom_on,
   input  logic              pll_en,
   input  logic [1:0]        pll_mode,
   output logic              ick_gate_en,
   output logic              slow_gate_en,
   output logic              sr_gate_en,
   output logic              pll_gate_en
);
   localparam int MAX_MOD = 32;

   if (N_MOD < 1 || N_MOD > MAX_MOD) begin : g_bad_nmod
      $error("pdcg_ctrl: N_MOD out of range");
   end
   if (N_SLOW < 1) begin : g_bad_nslow
      $error("pdcg_ctrl: N_SLOW must be at least 1");
   end

   logic [N_MOD-1:0] idle_ok;

   for (genvar i = 0; i < N_MOD; i++) begin : g_mod
      pdcg_mod_idle u_idle (
         .clk      (clk),
         .rst_n    (rst_n),
         .en       (mod_en[i]),
         .autoidle (mod_autoidle[i]),
         .req      (mod_req[i]),
         .ack      (idle_ack[i]),
         .idle_ok  (idle_ok[i])
      );
   end

   logic ick_d, slow_d, sr_d, pll_d, sr_done;

   assign ick_d   = ~(&idle_ok);
   assign slow_d  = |slow_en;
   assign sr_done = dom_on ? restore_done : save_done;
   assign sr_d    = sr_enable & ~sr_done;
   assign pll_d   = pll_en & (pll_mode_e'(pll_mode) == PLL_LOCKED);

   pdcg_gate_flop #(.RST_VAL(1'b1)) u_ick  (.clk(clk), .rst_n(rst_n), .d(ick_d),  .q(ick_gate_en));
   pdcg_gate_flop #(.RST_VAL(1'b0)) u_slow (.clk(clk), .rst_n(rst_n), .d(slow_d), .q(slow_gate_en));
   pdcg_gate_flop #(.RST_VAL(1'b0)) u_sr   (.clk(clk), .rst_n(rst_n), .d(sr_d),   .q(sr_gate_en));
   pdcg_gate_flop #(.RST_VAL(1'b0)) u_pll  (.clk(clk), .rst_n(rst_n), .d(pll_d),  .q(pll_gate_en));
endmodule

// File: rtl/pdcg_chk.sv
module pdcg_chk #(
   parameter int N_MOD  = 4,
   parameter int N_SLOW = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_MOD-1:0]  mod_en,
   input logic [N_MOD-1:0]  mod_autoidle,
   input logic [N_MOD-1:0]  mod_req,
   input logic [N_MOD-1:0]  idle_ack,
   input logic [N_SLOW-1:0] slow_en,
   input logic              sr_enable,
   input logic              pll_mode_locked_n,
   input logic              ick_gate_en,
   input logic              slow_gate_en,
   input logic              sr_gate_en,
   input logic              pll_gate_en
);
   p_all_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_en == '0) |=> !ick_gate_en);

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|(mod_en & ~mod_autoidle)) |=> ick_gate_en);

   p_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (idle_ack == $past(mod_autoidle & ~mod_req)));

   p_gate_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ick_gate_en) |->
         ($past((mod_en & ~(mod_autoidle & idle_ack & ~mod_req))) == '0));

   p_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|(mod_en & mod_req)) |=> ick_gate_en);

   p_slow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (slow_gate_en == $past(|slow_en)));

   p_sr_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !sr_enable |=> !sr_gate_en);

   p_pll_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pll_mode_locked_n |=> !pll_gate_en);
endmodule

bind pdcg_ctrl pdcg_chk #(.N_MOD(N_MOD), .N_SLOW(N_SLOW)) u_chk (
   .clk               (clk),
   .rst_n             (rst_n),
   .mod_en            (mod_en),
   .mod_autoidle      (mod_autoidle),
   .mod_req           (mod_req),
   .idle_ack          (idle_ack),
   .slow_en           (slow_en),
   .sr_enable         (sr_enable),
   .pll_mode_locked_n (pll_mode != 2'b10),
   .ick_gate_en       (ick_gate_en),
   .slow_gate_en      (slow_gate_en),
   .sr_gate_en        (sr_gate_en),
   .pll_gate_en       (pll_gate_en)
);

// File: tb/sim_pdcg_ctrl.sv
`timescale 1ns/1ps
module sim_pdcg_ctrl;
   localparam int NM = 4;
   localparam int NS = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NM-1:0] mod_en = '0, mod_autoidle = '0, mod_req = '0;
   logic [NM-1:0] idle_ack;
   logic [NS-1:0] slow_en = '0;
   logic sr_enable = 1'b0, save_done = 1'b0, restore_done = 1'b0, dom_on = 1'b1;
   logic pll_en = 1'b0;
   logic [1:0] pll_mode = 2'b00;
   logic ick_gate_en, slow_gate_en, sr_gate_en, pll_gate_en;

   int nvec = 0;
   int nerr = 0;
   logic [NM-1:0] ack_m = '0;
   logic e_ick, e_slow, e_sr, e_pll;
   logic [NM-1:0] e_ack;

   always #10 clk = ~clk;

   pdcg_ctrl #(.N_MOD(NM), .N_SLOW(NS)) u0 (
      .clk(clk), .rst_n(rst_n),
      .mod_en(mod_en), .mod_autoidle(mod_autoidle), .mod_req(mod_req),
      .idle_ack(idle_ack), .slow_en(slow_en),
      .sr_enable(sr_enable), .save_done(save_done), .restore_done(restore_done),
      .dom_on(dom_on), .pll_en(pll_en), .pll_mode(pll_mode),
      .ick_gate_en(ick_gate_en), .slow_gate_en(slow_gate_en),
      .sr_gate_en(sr_gate_en), .pll_gate_en(pll_gate_en)
   );

   function automatic logic f_ick(logic [NM-1:0] en, logic [NM-1:0] ai,
                                  logic [NM-1:0] rq, logic [NM-1:0] ak);
      return ~(&(~en | (ai & ak & ~rq)));
   endfunction

   function automatic logic f_sr(logic s, logic on, logic sd, logic rd);
      return s & ~(on ? rd : sd);
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // one clock: model at the edge, compare at the following falling edge
   task automatic step();
      @(posedge clk);
      e_ick  = f_ick(mod_en, mod_autoidle, mod_req, ack_m);
      e_ack  = mod_autoidle & ~mod_req;
      e_slow = |slow_en;
      e_sr   = f_sr(sr_enable, dom_on, save_done, restore_done);
      e_pll  = pll_en & (pll_mode == 2'b10);
      ack_m  = e_ack;
      @(negedge clk);
      chk("R5 ick_gate_en", 32'(ick_gate_en), 32'(e_ick));
      chk("R4 idle_ack",    32'(idle_ack),    32'(e_ack));
      chk("R7 slow_gate_en", 32'(slow_gate_en), 32'(e_slow));
      chk("R8 sr_gate_en",  32'(sr_gate_en),  32'(e_sr));
      chk("R9 pll_gate_en", 32'(pll_gate_en), 32'(e_pll));
   endtask

   initial begin
      #4000000;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      mod_en = 4'hF; slow_en = 4'hF; sr_enable = 1'b1; pll_en = 1'b1; pll_mode = 2'b10;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset values while reset is held
      chk("R1 ick reset",  32'(ick_gate_en),  32'd1);
      chk("R1 slow reset", 32'(slow_gate_en), 32'd0);
      chk("R1 sr reset",   32'(sr_gate_en),   32'd0);
      chk("R1 pll reset",  32'(pll_gate_en),  32'd0);
      chk("R1 ack reset",  32'(idle_ack),     32'd0);
      mod_en = '0; mod_autoidle = '0; mod_req = '0; slow_en = '0;
      sr_enable = 1'b0; pll_en = 1'b0; pll_mode = 2'b00;
      rst_n = 1'b1;
      ack_m = '0;

      // R2: everything disabled stops the interface clock
      mod_req = 4'hF;
      step();
      chk("R2 all enables off", 32'(ick_gate_en), 32'd0);

      // R3: enabled without auto-idle keeps clock up, request ignored
      mod_en = 4'b0001; mod_autoidle = 4'b0000; mod_req = 4'b0000;
      step(); step(); step();
      chk("R3 no auto-idle holds clock", 32'(ick_gate_en), 32'd1);

      // R5 mixed case with R4 acknowledge latency
      mod_en = 4'b0100; mod_autoidle = 4'b0100; mod_req = 4'b0100;
      step();
      chk("R5 requesting keeps clock", 32'(ick_gate_en), 32'd1);
      mod_req = 4'b0000;
      step();
      chk("R4 ack one cycle after drop", 32'(idle_ack[2]), 32'd1);
      chk("R5 clock waits for ack", 32'(ick_gate_en), 32'd1);
      step();
      chk("R5 mixed case gates", 32'(ick_gate_en), 32'd0);

      // R6: a new request wakes the clock at the next edge
      mod_req = 4'b0100;
      step();
      chk("R6 request wakes clock", 32'(ick_gate_en), 32'd1);

      // R5: all pairs set, no requests
      mod_en = 4'hF; mod_autoidle = 4'hF; mod_req = '0;
      step(); step();
      chk("R5 all pairs idle gates", 32'(ick_gate_en), 32'd0);

      // R7 single slow user
      slow_en = 4'b1000;
      step();
      chk("R7 one slow user runs", 32'(slow_gate_en), 32'd1);

      // R8 save-restore sequence
      sr_enable = 1'b1; dom_on = 1'b0; save_done = 1'b0; restore_done = 1'b1;
      step();
      chk("R8 saving runs", 32'(sr_gate_en), 32'd1);
      save_done = 1'b1;
      step();
      chk("R8 off and saved gates", 32'(sr_gate_en), 32'd0);
      dom_on = 1'b1; restore_done = 1'b0;
      step();
      chk("R8 restoring runs", 32'(sr_gate_en), 32'd1);
      restore_done = 1'b1;
      step();
      chk("R8 on and restored gates", 32'(sr_gate_en), 32'd0);

      // R9 each PLL mode code
      pll_en = 1'b1;
      for (int m = 0; m < 4; m++) begin
         pll_mode = 2'(m);
         step();
         chk("R9 pll mode", 32'(pll_gate_en), (m == 2) ? 32'd1 : 32'd0);
      end

      // random phase, alternating free and quiet stretches
      for (int blk = 0; blk < 600; blk++) begin
         logic quiet;
         quiet = ($urandom % 2) == 0;
         for (int k = 0; k < 5; k++) begin
            if (quiet) begin
               mod_en       = 4'($urandom);
               mod_autoidle = 4'hF;
               mod_req      = (($urandom % 8) == 0) ? 4'($urandom) : 4'h0;
            end else begin
               mod_en       = 4'($urandom);
               mod_autoidle = 4'($urandom);
               mod_req      = 4'($urandom);
            end
            slow_en      = (($urandom % 3) == 0) ? 4'h0 : 4'($urandom);
            sr_enable    = 1'($urandom);
            save_done    = 1'($urandom);
            restore_done = 1'($urandom);
            dom_on       = 1'($urandom);
            pll_en       = 1'($urandom);
            pll_mode     = 2'($urandom);
            step();
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end
endmodule